// File: doc/BRIEF.md
# Narrow-Mode PC Capability Boundary Checker

This block holds the program counter of a capability machine whose current address width can be narrower than the full capability address width. It is meant for the case where the narrow width is 32 bits and the full width is a parameter. While the narrow width is selected, the capability address that the block exports is always the sign extension of the narrow pc. Every update keeps this true: a control transfer write, a trap return, or a sequential step.

For each instruction fetch, the block works out the address of every byte of the instruction. In narrow mode each byte address is sign-extended on its own before it is compared with the decoded capability bounds. The fetch then gets one of three outcomes. A length violation is raised when bytes fall outside the bounds, or when the instruction crosses the half-range point or the wrap-to-zero point of the narrow address space. A fetch that does neither completes. An instruction that ends exactly on one of those points completes, but it leaves the pc unrepresentable. That state is remembered, and the next fetch raises a tag violation with an untagged exception pc, unless a trap input says that another event was taken instead.

Results are registered one cycle after the fetch strobe. Each result carries a cause code, the exception pc address and its tag.

Top module: `npc_bound_chk`

## Requirements
- R1: After a pc write, `pc_cap_addr` equals the written address when the mode is wide. When the mode is narrow, it equals the low 32 bits of the written address sign-extended, so upper bits of the write are ignored.
- R2: A fetch that completes moves `pc_cap_addr` forward by the instruction length. The length is 2 bytes when `fetch_len4`=0 and 4 bytes when it is 1. In narrow mode the sum wraps at 32 bits and is then sign-extended.
- R3: Each byte of a fetch is in bounds when `cap_base` <= addr < `cap_top`, compared unsigned at full width. In narrow mode each byte address is sign-extended from 32 bits before the compare; in wide mode it is not. Any active byte out of bounds gives cause 1, the length violation.
- R4: In narrow mode, without infinite bounds, a fetch whose bytes cross the 0x8000_0000 point or wrap from 0xFFFF_FFFF to 0 gives cause 1, even if every byte is in bounds. On any length violation, `epc_addr` is the fetch start address, `epc_tag` is 1, and the pc does not move.
- R5: While `cap_inf`=1, no fetch gives cause 1, whatever the bounds and whatever boundary is crossed.
- R6: A narrow-mode fetch without infinite bounds that ends exactly at 0 or 0x8000_0000 completes with cause 0 and tag 1. The next fetch then gives cause 2, the tag violation, with `epc_tag`=0, an `epc_addr` whose low 31 bits are zero, and an unchanged pc. The fetch after that is checked normally.
- R7: When `trap_take`=1 with a fetch, the result is cause 0 and `epc_addr` is the current pc. `epc_tag` is 0 if a tag violation was pending and 1 otherwise. The pending flag is cleared and the pc does not move.
- R8: A pc write clears a pending tag violation, so the next fetch is checked normally.
- R9: `res_vld` is high exactly in the cycle after a cycle with `fetch_vld` high. Out of reset, `res_vld`=0, `res_cause`=0 and `pc_cap_addr`=0. A completed fetch reports cause 0, tag 1 and `epc_addr` equal to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| narrow_mode | input | 1 | 1 selects the 32-bit current width, 0 selects full width |
| pc_wr_en | input | 1 | Control transfer or trap return writes a new pc |
| pc_wr_addr | input | XLENMAX | Target address of the pc write |
| fetch_vld | input | 1 | An instruction fetch at the current pc is checked this cycle |
| fetch_len4 | input | 1 | Instruction length: 0 means 2 bytes, 1 means 4 bytes |
| cap_base | input | XLENMAX | Lower bound of the pc capability, inclusive |
| cap_top | input | XLENMAX | Upper bound of the pc capability, exclusive |
| cap_inf | input | 1 | The capability has infinite bounds |
| trap_take | input | 1 | An interrupt or higher-priority exception is taken for this fetch |
| pc_cap_addr | output | XLENMAX | Capability address of the pc |
| res_vld | output | 1 | Result strobe, one cycle after `fetch_vld` |
| res_cause | output | 2 | 0 completed or no fault, 1 length violation, 2 tag violation |
| epc_addr | output | XLENMAX | Exception pc address of the checked fetch |
| epc_tag | output | 1 | Tag of the exception pc |

## Verification
The deferred tag violation is the hardest state to reach from the ports. It needs a fetch that stays inside finite bounds and ends exactly on a narrow-mode wrap point. The wrap to zero cannot satisfy this, because its last byte sign-extends to all ones and can never be below any top. The stimulus therefore writes the pc just below 0x8000_0000, uses a top of all ones, and fetches forward onto the half-range point. Follow-up fetches then probe the tag fault, its suppression by `trap_take`, and its clearing by a pc write.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LEN  = 2'd1,
    CAUSE_TAG  = 2'd2
  } cause_e;
endpackage

// File: rtl/npc_byte_window.sv
// Per-byte address generation and bounds test for one fetch.
module npc_byte_window #(
  parameter int XLENMAX  = 64,
  parameter int NARROW   = 32,
  parameter int ILEN_MAX = 4,
  parameter int ILEN_MIN = 2
) (
  input  logic               narrow,
  input  logic               len_long,
  input  logic [XLENMAX-1:0] pc,
  input  logic [XLENMAX-1:0] base,
  input  logic [XLENMAX-1:0] top,
  output logic               all_in,
  output logic               straddle,
  output logic               end_edge,
  output logic [XLENMAX-1:0] next_pc
);
  localparam int UPW = XLENMAX - NARROW;

  logic [ILEN_MAX-1:0] byte_act;
  logic [ILEN_MAX-1:0] byte_in;
  logic [ILEN_MAX-1:0] byte_wrap;
  logic [XLENMAX-1:0]  step;
  logic [XLENMAX-1:0]  next_raw;

  for (genvar i = 0; i < ILEN_MAX; i++) begin : g_byte
    logic [XLENMAX-1:0] raw;
    logic [XLENMAX-1:0] chk_a;
    assign raw         = pc + XLENMAX'(i);
    assign chk_a       = narrow ? {{UPW{raw[NARROW-1]}}, raw[NARROW-1:0]} : raw;
    assign byte_act[i] = (i < ILEN_MIN) ? 1'b1 : len_long;
    assign byte_in[i]  = (chk_a >= base) && (chk_a < top);
    if (i == 0) begin : g_first
      assign byte_wrap[i] = 1'b0;
    end else begin : g_rest
      // a later byte landing on a low-31-zero address crossed a wrap point
      assign byte_wrap[i] = narrow && (raw[NARROW-2:0] == '0);
    end
  end

  assign all_in   = &(byte_in | ~byte_act);
  assign straddle = |(byte_wrap & byte_act);
  assign step     = len_long ? XLENMAX'(ILEN_MAX) : XLENMAX'(ILEN_MIN);
  assign next_raw = pc + step;
  assign next_pc  = narrow ? {{UPW{next_raw[NARROW-1]}}, next_raw[NARROW-1:0]} : next_raw;
  assign end_edge = narrow && (next_raw[NARROW-2:0] == '0);
endmodule

// File: rtl/npc_pc_state.sv
// PC register and the pending-unrepresentable flag.
module npc_pc_state #(
  parameter int XLENMAX = 64,
  parameter int NARROW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               narrow,
  input  logic               wr_en,
  input  logic [XLENMAX-1:0] wr_addr,
  input  logic               adv_en,
  input  logic [XLENMAX-1:0] adv_pc,
  input  logic               set_pend,
  input  logic               clr_pend,
  output logic [XLENMAX-1:0] pc_q,
  output logic               pend_q
);
  localparam int UPW = XLENMAX - NARROW;

  logic [XLENMAX-1:0] pc_d;
  logic               pc_en;
  logic               pend_d;

  always_comb begin
    pc_en = wr_en || adv_en;
    if (wr_en) begin
      pc_d = narrow ? {{UPW{wr_addr[NARROW-1]}}, wr_addr[NARROW-1:0]} : wr_addr;
    end else begin
      pc_d = adv_pc;
    end
    if (clr_pend) begin
      pend_d = 1'b0;
    end else if (set_pend) begin
      pend_d = 1'b1;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/npc_bound_chk.sv
// Top: fetch outcome selection and registered result.
module npc_bound_chk #(
  parameter int XLENMAX  = 64,
  parameter int NARROW   = 32,
  parameter int ILEN_MAX = 4,
  parameter int ILEN_MIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               narrow_mode,
  input  logic               pc_wr_en,
  input  logic [XLENMAX-1:0] pc_wr_addr,
  input  logic               fetch_vld,
  input  logic               fetch_len4,
  input  logic [XLENMAX-1:0] cap_base,
  input  logic [XLENMAX-1:0] cap_top,
  input  logic               cap_inf,
  input  logic               trap_take,
  output logic [XLENMAX-1:0] pc_cap_addr,
  output logic               res_vld,
  output logic [1:0]         res_cause,
  output logic [XLENMAX-1:0] epc_addr,
  output logic               epc_tag
);
  import npc_pkg::*;

  logic               rst_meta_q, rst_n_sync;
  logic               all_in, straddle, end_edge;
  logic [XLENMAX-1:0] next_pc, pc_q;
  logic               pend_q;
  logic               len_bad, adv_en, set_pend, clr_pend;
  cause_e             cause_d, cause_q;
  logic               tag_d, tag_q, vld_q;
  logic [XLENMAX-1:0] epc_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  npc_byte_window #(
    .XLENMAX(XLENMAX), .NARROW(NARROW), .ILEN_MAX(ILEN_MAX), .ILEN_MIN(ILEN_MIN)
  ) win_i (
    .narrow(narrow_mode), .len_long(fetch_len4), .pc(pc_q),
    .base(cap_base), .top(cap_top),
    .all_in(all_in), .straddle(straddle), .end_edge(end_edge), .next_pc(next_pc)
  );

  always_comb begin
    len_bad  = !cap_inf && (!all_in || straddle);
    adv_en   = 1'b0;
    set_pend = 1'b0;
    cause_d  = CAUSE_NONE;
    tag_d    = 1'b1;
    if (fetch_vld) begin
      if (trap_take) begin
        tag_d = !pend_q;
      end else if (pend_q) begin
        cause_d = CAUSE_TAG;
        tag_d   = 1'b0;
      end else if (len_bad) begin
        cause_d = CAUSE_LEN;
      end else begin
        adv_en   = 1'b1;
        set_pend = end_edge && !cap_inf;
      end
    end
    clr_pend = pc_wr_en || trap_take || (fetch_vld && pend_q);
  end

  npc_pc_state #(.XLENMAX(XLENMAX), .NARROW(NARROW)) pcs_i (
    .clk(clk), .rst_n(rst_n_sync), .narrow(narrow_mode),
    .wr_en(pc_wr_en), .wr_addr(pc_wr_addr),
    .adv_en(adv_en && !pc_wr_en), .adv_pc(next_pc),
    .set_pend(set_pend), .clr_pend(clr_pend),
    .pc_q(pc_q), .pend_q(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      vld_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      tag_q   <= 1'b0;
      epc_q   <= '0;
    end else begin
      vld_q   <= fetch_vld;
      cause_q <= cause_d;
      if (fetch_vld) begin
        tag_q <= tag_d;
        epc_q <= pc_q;
      end
    end
  end

  assign pc_cap_addr = pc_q;
  assign res_vld     = vld_q;
  assign res_cause   = cause_q;
  assign epc_addr    = epc_q;
  assign epc_tag     = tag_q;
endmodule

// File: rtl/npc_bound_chk_sva.sv
module npc_bound_chk_sva #(
  parameter int XLENMAX  = 64,
  parameter int NARROW   = 32,
  parameter int ILEN_MAX = 4,
  parameter int ILEN_MIN = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               narrow_mode,
  input logic               pc_wr_en,
  input logic [XLENMAX-1:0] pc_wr_addr,
  input logic               fetch_vld,
  input logic               fetch_len4,
  input logic               cap_inf,
  input logic               trap_take,
  input logic [XLENMAX-1:0] pc_cap_addr,
  input logic               res_vld,
  input logic [1:0]         res_cause,
  input logic [XLENMAX-1:0] epc_addr,
  input logic               epc_tag
);
  localparam int UPW = XLENMAX - NARROW;

  logic               past_ok;
  logic [XLENMAX-1:0] wr_exp;
  logic [XLENMAX-1:0] adv_raw4, adv_raw2, adv_exp4, adv_exp2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign wr_exp   = narrow_mode ? {{UPW{pc_wr_addr[NARROW-1]}}, pc_wr_addr[NARROW-1:0]} : pc_wr_addr;
  assign adv_raw4 = epc_addr + XLENMAX'(ILEN_MAX);
  assign adv_raw2 = epc_addr + XLENMAX'(ILEN_MIN);
  assign adv_exp4 = narrow_mode ? {{UPW{adv_raw4[NARROW-1]}}, adv_raw4[NARROW-1:0]} : adv_raw4;
  assign adv_exp2 = narrow_mode ? {{UPW{adv_raw2[NARROW-1]}}, adv_raw2[NARROW-1:0]} : adv_raw2;

  // R1
  pc_wr_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(pc_wr_en) |-> pc_cap_addr == $past(wr_exp));

  // R2
  pc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fetch_vld && !trap_take && !pc_wr_en && narrow_mode) && narrow_mode
      && res_vld && res_cause == 2'd0 && epc_tag
      |-> pc_cap_addr == ($past(fetch_len4) ? adv_exp4 : adv_exp2));

  // R4
  len_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_cause == 2'd1 |-> epc_tag);

  // R5
  inf_no_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fetch_vld && cap_inf) |-> res_cause != 2'd1);

  // R6
  tag_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_cause == 2'd2 |-> !epc_tag && epc_addr[NARROW-2:0] == '0);

  // R7
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fetch_vld && trap_take) |-> res_cause == 2'd0);

  // R9
  vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> res_vld == $past(fetch_vld));
endmodule

bind npc_bound_chk npc_bound_chk_sva #(
  .XLENMAX(XLENMAX), .NARROW(NARROW), .ILEN_MAX(ILEN_MAX), .ILEN_MIN(ILEN_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n_sync), .narrow_mode(narrow_mode),
  .pc_wr_en(pc_wr_en), .pc_wr_addr(pc_wr_addr),
  .fetch_vld(fetch_vld), .fetch_len4(fetch_len4),
  .cap_inf(cap_inf), .trap_take(trap_take),
  .pc_cap_addr(pc_cap_addr), .res_vld(res_vld), .res_cause(res_cause),
  .epc_addr(epc_addr), .epc_tag(epc_tag)
);

// File: tb/npc_bound_chk_tb_top.sv
module npc_bound_chk_tb_top;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SX80 = 64'hFFFF_FFFF_8000_0000;

  typedef struct packed {
    logic        nar;
    logic        l4;
    logic        inf;
    logic [63:0] pcw;
    logic [63:0] base;
    logic [63:0] top;
    logic [1:0]  cause;
    logic        tag;
    logic [63:0] epc;
    logic [63:0] nxt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 64'h1000, 64'h0, 64'h2000, 2'd0, 1'b1, 64'h1000, 64'h1004},
    '{1'b1, 1'b1, 1'b0, 64'h1FFE, 64'h0, 64'h2000, 2'd1, 1'b1, 64'h1FFE, 64'h1FFE},
    '{1'b1, 1'b1, 1'b0, 64'h7FFF_FFFE, 64'h0, ONES, 2'd1, 1'b1, 64'h7FFF_FFFE, 64'h7FFF_FFFE},
    '{1'b1, 1'b1, 1'b1, 64'h7FFF_FFFE, 64'h0, 64'h10, 2'd0, 1'b1, 64'h7FFF_FFFE, 64'hFFFF_FFFF_8000_0002},
    '{1'b0, 1'b1, 1'b0, 64'h7FFF_FFFE, 64'h0, 64'h1_0000_0000, 2'd0, 1'b1, 64'h7FFF_FFFE, 64'h8000_0002},
    '{1'b1, 1'b1, 1'b0, 64'hFFFF_FFFE, 64'hFFFF_FFFF_FFFF_FF00, ONES, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE},
    '{1'b1, 1'b0, 1'b0, 64'hABCD_0000_0000_1000, 64'h0, 64'h2000, 2'd0, 1'b1, 64'h1000, 64'h1002},
    '{1'b1, 1'b0, 1'b0, 64'h2000, 64'h1000, 64'h2002, 2'd0, 1'b1, 64'h2000, 64'h2002},
    '{1'b1, 1'b0, 1'b0, 64'h2000, 64'h1000, 64'h2001, 2'd1, 1'b1, 64'h2000, 64'h2000},
    '{1'b1, 1'b0, 1'b0, 64'h2000, 64'h2001, 64'h3000, 2'd1, 1'b1, 64'h2000, 64'h2000},
    '{1'b0, 1'b0, 1'b0, 64'h8000_0000, 64'h8000_0000, 64'h8000_0010, 2'd0, 1'b1, 64'h8000_0000, 64'h8000_0002},
    '{1'b1, 1'b0, 1'b0, 64'h8000_0000, 64'h8000_0000, 64'h8000_0010, 2'd1, 1'b1, SX80, SX80}
  };

  logic        clk, rst_n, narrow_mode, pc_wr_en, fetch_vld, fetch_len4, cap_inf, trap_take;
  logic [63:0] pc_wr_addr, cap_base, cap_top, pc_cap_addr, epc_addr;
  logic        res_vld, epc_tag;
  logic [1:0]  res_cause;
  int          n_run, n_fail;

  npc_bound_chk dut_i (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .pc_wr_en(pc_wr_en), .pc_wr_addr(pc_wr_addr),
    .fetch_vld(fetch_vld), .fetch_len4(fetch_len4),
    .cap_base(cap_base), .cap_top(cap_top), .cap_inf(cap_inf), .trap_take(trap_take),
    .pc_cap_addr(pc_cap_addr), .res_vld(res_vld), .res_cause(res_cause),
    .epc_addr(epc_addr), .epc_tag(epc_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pc_write(input logic nar, input logic [63:0] a);
    @(negedge clk);
    narrow_mode = nar; pc_wr_en = 1'b1; pc_wr_addr = a;
    @(negedge clk);
    pc_wr_en = 1'b0;
  endtask

  // one fetch cycle; returns with outputs of that fetch observable
  task automatic fetch(input logic l4, input logic [63:0] b, input logic [63:0] t,
                       input logic inf, input logic trap);
    fetch_vld = 1'b1; fetch_len4 = l4; cap_base = b; cap_top = t; cap_inf = inf; trap_take = trap;
    @(negedge clk);
    fetch_vld = 1'b0; trap_take = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [1:0] c, input logic tg,
                            input logic [63:0] e, input logic [63:0] p);
    chk(req, "res_vld", 64'(res_vld), 64'd1);
    chk(req, "cause", 64'(res_cause), 64'(c));
    chk(req, "tag", 64'(epc_tag), 64'(tg));
    chk(req, "epc", epc_addr, e);
    chk(req, "pc", pc_cap_addr, p);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; narrow_mode = 1'b1; pc_wr_en = 1'b0; pc_wr_addr = '0;
    fetch_vld = 1'b0; fetch_len4 = 1'b0; cap_base = '0; cap_top = '0; cap_inf = 1'b0; trap_take = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset res_vld", 64'(res_vld), 64'd0);
    chk("R9", "reset cause", 64'(res_cause), 64'd0);
    chk("R9", "reset pc", pc_cap_addr, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table: R1 sign-extended writes, R2 advance, R3 bounds, R4 straddle, R5 inf
    for (int k = 0; k < NV; k++) begin
      pc_write(VECS[k].nar, VECS[k].pcw);
      fetch(VECS[k].l4, VECS[k].base, VECS[k].top, VECS[k].inf, 1'b0);
      expect_res($sformatf("R1/R2/R3/R4/R5 vec%0d", k), VECS[k].cause, VECS[k].tag, VECS[k].epc, VECS[k].nxt);
    end
    @(negedge clk);
    chk("R9", "strobe drops", 64'(res_vld), 64'd0);

    // R6 deferred tag fault at the half-range point
    pc_write(1'b1, 64'h7FFF_FFFC);
    fetch(1'b1, 64'h0, ONES, 1'b0, 1'b0);
    expect_res("R6 edge completes", 2'd0, 1'b1, 64'h7FFF_FFFC, SX80);
    fetch(1'b1, 64'h0, ONES, 1'b0, 1'b0);
    expect_res("R6 tag fault", 2'd2, 1'b0, SX80, SX80);
    fetch(1'b1, 64'h0, ONES, 1'b0, 1'b0);
    expect_res("R6 after fault", 2'd0, 1'b1, SX80, 64'hFFFF_FFFF_8000_0004);

    // R7 trap taken instead of the tag fault
    pc_write(1'b1, 64'h7FFF_FFFE);
    fetch(1'b0, 64'h0, ONES, 1'b0, 1'b0);
    expect_res("R7 edge completes", 2'd0, 1'b1, 64'h7FFF_FFFE, SX80);
    fetch(1'b0, 64'h0, ONES, 1'b0, 1'b1);
    expect_res("R7 trap suppresses", 2'd0, 1'b0, SX80, SX80);
    fetch(1'b0, 64'h0, ONES, 1'b0, 1'b0);
    expect_res("R7 pend cleared", 2'd0, 1'b1, SX80, 64'hFFFF_FFFF_8000_0002);
    fetch(1'b1, 64'h0, 64'h10, 1'b0, 1'b1);
    expect_res("R7 trap hides len", 2'd0, 1'b1, 64'hFFFF_FFFF_8000_0002, 64'hFFFF_FFFF_8000_0002);

    // R8 pc write clears pending
    pc_write(1'b1, 64'h7FFF_FFFC);
    fetch(1'b1, 64'h0, ONES, 1'b0, 1'b0);
    expect_res("R8 edge completes", 2'd0, 1'b1, 64'h7FFF_FFFC, SX80);
    pc_write(1'b1, 64'h1000);
    fetch(1'b1, 64'h0, 64'h2000, 1'b0, 1'b0);
    expect_res("R8 no tag fault", 2'd0, 1'b1, 64'h1000, 64'h1004);

    // R5 infinite bounds: edge ending sets nothing
    pc_write(1'b1, 64'h7FFF_FFFC);
    fetch(1'b1, 64'h0, 64'h0, 1'b1, 1'b0);
    expect_res("R5 inf edge", 2'd0, 1'b1, 64'h7FFF_FFFC, SX80);
    fetch(1'b1, 64'h0, 64'h0, 1'b1, 1'b0);
    expect_res("R5 inf next", 2'd0, 1'b1, SX80, 64'hFFFF_FFFF_8000_0004);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule